// File: doc/BRIEF.md
# Prescaled Compare-Match Event Timer

This block is a 16-bit event timer for timekeeping and scheduler ticks. A slow reference tick (one-cycle pulses in the system clock domain, nominally 32.768 kHz) feeds a power-of-two prescaler. The prescaler advances a writable up-counter once every 2^scale reference ticks while the counter is enabled. Two compare registers watch the counter. A match on the primary compare register wraps the counter back to zero, and the counter carries on counting. A match on the secondary compare register only raises its own flag.

Software works the block through four 16-bit registers on a simple write-strobe bus with a combinational read path. The configuration register holds the run bit, the scale, a 2-bit event mode for each comparator, a read-only "configured" bit and two sticky match flags. The flags are cleared by writing ones to them. One write can therefore stop the counter and clear both flags. One-shot use is disable, preload the count, program the compare value and re-enable. Periodic use leaves the counter running through its automatic wraps.

Top module: `evt_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: While the run bit (config bit 15) is 1, the counter advances by one on every 2^s-th reference tick, where s is config bits 3:0 and values above 8 count as 8.
- R3: A write to the counter register (address 2) loads the written value on the next edge.
- R4: While the run bit is 0, the counter holds its value.
- R5: An advance step taken while the counter equals the primary compare register (address 1) loads 0 into the counter. If primary mode bit 0 (config bit 8) is 1, the step also sets the primary flag (config bit 14).
- R6: An advance step taken while the counter equals the secondary compare register (address 3) sets the secondary flag (config bit 13) if secondary mode bit 0 (config bit 10) is 1. It does not change the count.
- R7: Writing 1 to a flag bit in a config write clears that flag, and writing 0 leaves it unchanged. A match in the same cycle as the clear wins, and the flag stays set.
- R8: `irq` is high exactly when some flag is set and that comparator's mode bit 1 is 1 (config bit 9 for primary, bit 11 for secondary). Mode value 3 enables both the flag and the interrupt.
- R9: Config bit 12 reads 1 after the first config write and stays 1. Writes to this bit have no effect.
- R10: The prescaler phase restarts from zero on a counter write and on a config write with the run bit at 0.
- R11: Addresses are 0 config, 1 primary compare, 2 counter, 3 secondary compare. Config bits 7:4 read 0. Reads return live state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle reference tick pulse |
| bus_addr | input | 2 | Register address for read and write |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the scale clamp, where a timer that does not saturate the scale would stall, and a scale change in the middle of a prescale period. It also covers a clear written in the very cycle a match fires, where a design that let the clear win would drop a tick. Further cases are counter writes in the middle of a prescale period, where a stale prescaler phase would shift the next step, and the secondary match, where a design that wrapped on it would cut the period short. Attempted writes to the read-only configured bit and flag-only mode without the interrupt are also exercised, since an interrupt there would be spurious.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 2;
  localparam int SCALE_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_CFG   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMPA  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMPB  = 2'd3;

  localparam int MODEA_LSB = 8;
  localparam int MODEB_LSB = 10;
  localparam int DONE_BIT  = 12;
  localparam int FLAGB_BIT = 13;
  localparam int FLAGA_BIT = 14;
  localparam int RUN_BIT   = 15;

  typedef struct packed {
    logic               run;
    logic [1:0]         mode_b;
    logic [1:0]         mode_a;
    logic [SCALE_W-1:0] scale;
  } cfg_t;

  function automatic int unsigned clamp_scale(logic [SCALE_W-1:0] s, int unsigned smax);
    return (int'(s) > int'(smax)) ? smax : int'(s);
  endfunction

  function automatic logic [REG_W-1:0] next_count(logic [REG_W-1:0] cur, logic wrap);
    return wrap ? '0 : cur + 1'b1;
  endfunction

  function automatic logic [REG_W-1:0] pack_cfg(cfg_t c, logic done, logic fa, logic fb);
    logic [REG_W-1:0] w;
    w = '0;
    w[SCALE_W-1:0]           = c.scale;
    w[MODEA_LSB+1:MODEA_LSB] = c.mode_a;
    w[MODEB_LSB+1:MODEB_LSB] = c.mode_b;
    w[DONE_BIT]              = done;
    w[FLAGB_BIT]             = fb;
    w[FLAGA_BIT]             = fa;
    w[RUN_BIT]               = c.run;
    return w;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import evt_timer_pkg::*;
#(
  parameter int SCALE_MAX = 8,
  localparam int PRE_W = (SCALE_MAX < 1) ? 1 : SCALE_MAX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic               run,
  input  logic               restart,
  input  logic [SCALE_W-1:0] scale,
  output logic               step
);
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] limit;
  logic             terminal;
  int unsigned      eff_scale;

  always_comb begin
    eff_scale = clamp_scale(scale, SCALE_MAX);
    limit     = PRE_W'((32'd1 << eff_scale) - 32'd1);
    terminal  = (phase_q >= limit);
    step      = ref_tick && run && terminal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= '0;
    else if (restart)        phase_q <= '0;
    else if (ref_tick && run) phase_q <= terminal ? '0 : phase_q + 1'b1;
  end

  // R10: an idle prescaler sits at phase zero
  assert_idle_phase_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> phase_q == '0);
  // R2: no step without a reference tick
  assert_step_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ref_tick);
endmodule

// File: rtl/match_unit.sv
module match_unit
  import evt_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmp,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] count,
  input  logic             step,
  input  logic [1:0]       mode,
  input  logic             clr,
  output logic [REG_W-1:0] cmp_val,
  output logic             hit,
  output logic             flag,
  output logic             irq_part
);
  logic [REG_W-1:0] cmp_q;
  logic             flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (wr_cmp) cmp_q <= wdata;
  end

  assign hit = step && (count == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag_q <= 1'b0;
    else if (hit && mode[0])    flag_q <= 1'b1;
    else if (clr)               flag_q <= 1'b0;
  end

  assign cmp_val  = cmp_q;
  assign flag     = flag_q;
  assign irq_part = flag_q && mode[1];

  // R7: a match beats a same-cycle clear
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit && mode[0] |=> flag);
  // R7: a flag only falls through an explicit clear
  assert_sticky_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);
endmodule

// File: rtl/up_counter.sv
module up_counter
  import evt_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] load_val,
  input  logic             step,
  input  logic             wrap,
  output logic [REG_W-1:0] count
);
  logic [REG_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (step) cnt_q <= next_count(cnt_q, wrap);
  end

  assign count = cnt_q;

  // R3: software load lands on the next edge
  assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int SCALE_MAX = 8,
  localparam int NCMP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);
  cfg_t             cfg_q;
  logic             done_q;
  logic             cfg_wr, cnt_wr;
  logic             step;
  logic [REG_W-1:0] count;
  logic [NCMP-1:0]  cmp_wr, clr, hit, flag, irq_part;
  logic [1:0]       mode [NCMP];
  logic [REG_W-1:0] cmp_val [NCMP];

  assign cfg_wr = bus_we && (bus_addr == ADDR_CFG);
  assign cnt_wr = bus_we && (bus_addr == ADDR_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else if (cfg_wr) begin
      cfg_q.run    <= bus_wdata[RUN_BIT];
      cfg_q.mode_a <= bus_wdata[MODEA_LSB+1:MODEA_LSB];
      cfg_q.mode_b <= bus_wdata[MODEB_LSB+1:MODEB_LSB];
      cfg_q.scale  <= bus_wdata[SCALE_W-1:0];
      done_q       <= 1'b1;
    end
  end

  tick_prescaler #(.SCALE_MAX(SCALE_MAX)) u_presc (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .run(cfg_q.run),
    .restart(cnt_wr || (cfg_wr && !bus_wdata[RUN_BIT])),
    .scale(cfg_q.scale), .step(step)
  );

  // index 0 is the primary (wrapping) comparator, index 1 the secondary
  assign cmp_wr[0] = bus_we && (bus_addr == ADDR_CMPA);
  assign cmp_wr[1] = bus_we && (bus_addr == ADDR_CMPB);
  assign clr[0]    = cfg_wr && bus_wdata[FLAGA_BIT];
  assign clr[1]    = cfg_wr && bus_wdata[FLAGB_BIT];
  assign mode[0]   = cfg_q.mode_a;
  assign mode[1]   = cfg_q.mode_b;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    match_unit u_match (
      .clk(clk), .rst_n(rst_n), .wr_cmp(cmp_wr[g]), .wdata(bus_wdata),
      .count(count), .step(step), .mode(mode[g]), .clr(clr[g]),
      .cmp_val(cmp_val[g]), .hit(hit[g]), .flag(flag[g]), .irq_part(irq_part[g])
    );
  end

  up_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_wr), .load_val(bus_wdata),
    .step(step), .wrap(hit[0]), .count(count)
  );

  assign irq = |irq_part;

  always_comb begin
    unique case (bus_addr)
      ADDR_CFG:   bus_rdata = pack_cfg(cfg_q, done_q, flag[0], flag[1]);
      ADDR_CMPA:  bus_rdata = cmp_val[0];
      ADDR_COUNT: bus_rdata = count;
      default:    bus_rdata = cmp_val[1];
    endcase
  end

  // R4: counter frozen while not running
  assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.run && !cnt_wr |=> $stable(count));
  // R5: primary match wraps to zero
  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] && !cnt_wr |=> count == '0);
  // R6: secondary match alone keeps counting upward
  assert_no_wrap_secondary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] && !hit[0] && !cnt_wr |=> count == $past(count) + 1'b1);
  // R8: interrupt needs a set flag
  assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |flag);
  // R9: configured bit never falls
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
endmodule

// File: tb/evt_timer_tb.sv
`timescale 1ns/100ps
module evt_timer_tb_top;
  localparam int SMAX = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        we = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0, fails = 0, cyc = 0, tick_mode = 0, tick_div = 0;
  bit chk_on = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_scale, m_ma, m_mb, m_en, m_fa, m_fb, m_done, m_cnt, m_ca, m_cb, m_pre;

  evt_timer #(.SCALE_MAX(SMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(tick), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    int sc, lim, n_pre, n_cnt;
    bit step, hita, hitb, wcfg, wcnt;
    cyc++;
    if (!rst_n) begin
      m_scale = 0; m_ma = 0; m_mb = 0; m_en = 0; m_fa = 0; m_fb = 0;
      m_done = 0; m_cnt = 0; m_ca = 0; m_cb = 0; m_pre = 0;
    end else begin
      sc   = (m_scale > SMAX) ? SMAX : m_scale;
      lim  = (1 << sc) - 1;
      step = tick && (m_en != 0) && (m_pre >= lim);
      wcfg = we && addr == 2'd0;
      wcnt = we && addr == 2'd2;
      hita = step && (m_cnt == m_ca);
      hitb = step && (m_cnt == m_cb);
      if (wcnt || (wcfg && !wdata[15])) n_pre = 0;
      else if (tick && m_en != 0) n_pre = step ? 0 : m_pre + 1;
      else n_pre = m_pre;
      if (wcnt) n_cnt = int'(wdata);
      else if (step) n_cnt = hita ? 0 : ((m_cnt + 1) & 16'hFFFF);
      else n_cnt = m_cnt;
      if (hita && (m_ma & 1) != 0) m_fa = 1;
      else if (wcfg && wdata[14]) m_fa = 0;
      if (hitb && (m_mb & 1) != 0) m_fb = 1;
      else if (wcfg && wdata[13]) m_fb = 0;
      if (wcfg) begin
        m_scale = int'(wdata[3:0]); m_ma = int'(wdata[9:8]);
        m_mb = int'(wdata[11:10]); m_en = int'(wdata[15]); m_done = 1;
      end
      if (we && addr == 2'd1) m_ca = int'(wdata);
      if (we && addr == 2'd3) m_cb = int'(wdata);
      m_pre = n_pre;
      m_cnt = n_cnt;
    end
  end

  always @(negedge clk) begin
    if (tick_mode == 1) tick <= 1'b1;
    else if (tick_mode == 2) begin
      tick <= (tick_div == 0);
      tick_div <= (tick_div == 2) ? 0 : tick_div + 1;
    end else tick <= 1'b0;
  end

  function automatic logic [15:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return {m_en[0], m_fa[0], m_fb[0], m_done[0], m_mb[1:0], m_ma[1:0],
                    4'b0000, m_scale[3:0]};
      2'd1: return m_ca[15:0];
      2'd2: return m_cnt[15:0];
      default: return m_cb[15:0];
    endcase
  endfunction

  always @(negedge clk) begin
    logic [15:0] er;
    logic ei;
    #1;
    if (chk_on) begin
      er = exp_read(addr);
      ei = ((m_fa != 0) && (m_ma & 2) != 0) || ((m_fb != 0) && (m_mb & 2) != 0);
      checks++;
      if (rdata !== er) begin
        fails++;
        $display("FAIL %s rdata addr %0d: actual %h expected %h", cur_req, addr, rdata, er);
      end
      checks++;
      if (irq !== ei) begin
        fails++;
        $display("FAIL %s irq: actual %b expected %b", cur_req, irq, ei);
      end
    end
  end

  function automatic logic [15:0] cfg(bit en, int sc, int ma, int mb, bit fa, bit fb);
    logic [15:0] w;
    w = 16'h0;
    w[3:0] = sc[3:0]; w[9:8] = ma[1:0]; w[11:10] = mb[1:0];
    w[14] = fa; w[13] = fb; w[15] = en;
    return w;
  endfunction

  task automatic wr(logic [1:0] a, logic [15:0] d, logic [1:0] idle);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = idle;
  endtask

  task automatic run(int n, logic [1:0] a);
    addr = a;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1;
    cur_req = "R1";
    for (int a = 0; a < 4; a++) begin addr = 2'(a); @(negedge clk); end

    cur_req = "R11";
    wr(2'd3, 16'h1234, 2'd3);
    wr(2'd1, 16'hBEEF, 2'd1);
    run(2, 2'd0);

    cur_req = "R2";
    wr(2'd1, 16'hFFFF, 2'd2);
    wr(2'd3, 16'hFFFF, 2'd2);
    tick_mode = 1;
    wr(2'd0, cfg(1, 0, 0, 0, 0, 0), 2'd2);
    run(20, 2'd2);
    tick_mode = 2;
    wr(2'd0, cfg(1, 3, 0, 0, 0, 0), 2'd2);
    run(100, 2'd2);
    tick_mode = 1;
    wr(2'd0, cfg(1, 12, 0, 0, 0, 0), 2'd2);   // clamps to 8
    run(600, 2'd2);

    cur_req = "R4";
    wr(2'd0, cfg(0, 0, 0, 0, 0, 0), 2'd2);
    run(30, 2'd2);

    cur_req = "R3";
    wr(2'd2, 16'h0100, 2'd2);
    wr(2'd0, cfg(1, 2, 0, 0, 0, 0), 2'd2);
    run(7, 2'd2);
    cur_req = "R10";
    wr(2'd2, 16'h0010, 2'd2);
    run(12, 2'd2);

    cur_req = "R5";
    wr(2'd2, 16'h0000, 2'd2);
    wr(2'd1, 16'h0005, 2'd2);
    wr(2'd0, cfg(1, 1, 3, 0, 0, 0), 2'd2);
    run(40, 2'd2);
    cur_req = "R8";
    run(5, 2'd0);

    cur_req = "R7";
    wr(2'd0, cfg(1, 1, 3, 0, 1, 0), 2'd0);
    run(3, 2'd0);
    wr(2'd1, 16'h0002, 2'd0);
    wr(2'd0, cfg(1, 0, 3, 0, 0, 0), 2'd0);
    for (int i = 0; i < 30; i++) wr(2'd0, cfg(1, 0, 3, 0, i[0], 0), 2'd0);
    run(10, 2'd0);

    cur_req = "R6";
    wr(2'd1, 16'h0020, 2'd2);
    wr(2'd3, 16'h0003, 2'd2);
    wr(2'd2, 16'h0000, 2'd2);
    wr(2'd0, cfg(1, 0, 0, 3, 1, 1), 2'd2);
    run(80, 2'd2);
    run(3, 2'd0);

    cur_req = "R9";
    wr(2'd0, 16'h0000, 2'd0);
    run(4, 2'd0);
    cur_req = "R8";
    wr(2'd3, 16'h0004, 2'd0);
    wr(2'd0, cfg(1, 0, 0, 1, 1, 1), 2'd0);
    run(30, 2'd0);
    wr(2'd0, cfg(1, 0, 0, 3, 0, 0), 2'd0);
    run(10, 2'd0);

    chk_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule